// File: doc/BRIEF.md
# Coincidence Trigger Former with Per-Input Delay and Stretch

This block turns six discriminated trigger lines into one global trigger-valid level. Each line is brought into the core clock domain (160 MHz nominal) through a two-flop synchroniser. A falling edge on the line produces a pulse one clock wide. That pulse is then shifted later by a per-input delay and widened by a per-input stretch, to make up for unequal cable lengths and unequal signal widths.

The six conditioned levels form a 6-bit pattern, with input 0 as the least significant bit. The pattern selects one bit of a 64-bit programmable truth table, and the selected bit is registered as the trigger-valid output. Only the exact patterns whose table bit is set count as triggers. An input that is active but absent from every selected pattern therefore works as a veto.

Top module: `trig_coinc_top`

## Requirements
- R1: Only a falling edge (1 to 0) on an input produces a pulse. A rising edge produces no pulse and leaves `trig_valid_o` unchanged.
- R2: Let E0 be the first clock edge that samples a new low value on an input. With delay 0 and stretch 0, that input's conditioned level is high for exactly the one cycle that follows edge E2.
- R3: The input's 5-bit delay field d moves the conditioned level d cycles later. Its first high cycle is the one after edge E2+d, for any d from 0 to 31.
- R4: The input's 5-bit stretch field s makes the conditioned level s+1 cycles wide. It stays high through the cycle after edge E2+d+s, for any s from 0 to 31. Stretch 0 gives a one-cycle level.
- R5: A new pulse that arrives while an input is still stretched reloads the stretch count. The level then stays high until s cycles after the new pulse.
- R6: The conditioned levels form a 6-bit index, with input 0 at bit 0 and input 5 at bit 5. `trig_valid_o` equals bit [index] of `trig_word_i`, registered one cycle later. It therefore rises one cycle after a matching pattern appears and falls one cycle after the pattern stops matching.
- R7: A set table bit matches only its exact pattern. For example, with only bit 1 set, any other active input vetoes the output. When a shorter pulse on another input overlaps a longer one, the output drops during the overlap and rises again after it, giving two separate valid pulses.
- R8: While `rst_ni` is low, `trig_valid_o` is 0. After reset, no pulse is produced until an input is seen high and then low.
- R9: Configuration is per input. Input i takes its delay from `delay_cfg_i[5i+4:5i]` and its stretch from `stretch_cfg_i[5i+4:5i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_in_i | input | 6 | Discriminated trigger lines, asynchronous |
| delay_cfg_i | input | 30 | Per-input delay, 5 bits per input |
| stretch_cfg_i | input | 30 | Per-input stretch, 5 bits per input |
| trig_word_i | input | 64 | Truth table, one bit per input pattern |
| trig_valid_o | output | 1 | Registered global trigger-valid |

## Verification
The bench compares `trig_valid_o` cycle by cycle against a model of every window, for several input masks, table words, and delay and stretch settings, including the extremes 0 and 31. A design off by one register in the synchroniser or the delay tap would shift the whole window and miscompare at both ends. A design that fires on rising edges would show activity after the lines return high. A design that ignores a retrigger during stretch would end its window early. A design that treats the table as an OR of inputs instead of an exact pattern match would miss the veto case and the double-pulse case, where an overlapping short pulse must cut the output in two.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned N_IN  = 6;
  localparam int unsigned CFG_W = 5;
  localparam int unsigned LUT_W = 1 << N_IN;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic pulse_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prev_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      s1_q    <= line_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      pulse_o <= prev_q & ~s2_q;
    end
  end
endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int unsigned CFG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [CFG_W-1:0] dly_i,
  output logic             pulse_o
);
  localparam int unsigned DEPTH = (1 << CFG_W) - 1;

  logic [DEPTH-1:0] sr_q;
  logic [CFG_W-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], pulse_i};
  end

  assign tap     = dly_i - CFG_W'(1);
  assign pulse_o = (dly_i == '0) ? pulse_i : sr_q[tap];
endmodule

// File: rtl/trig_stretch.sv
module trig_stretch #(
  parameter int unsigned CFG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [CFG_W-1:0] str_i,
  output logic             level_o
);
  logic [CFG_W-1:0] cnt_q;

  // a fresh pulse always reloads, so retriggers extend the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (pulse_i)      cnt_q <= str_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CFG_W'(1);
  end

  assign level_o = pulse_i | (cnt_q != '0);
endmodule

// File: rtl/trig_coinc_top.sv
module trig_coinc_top
  import trig_pkg::*;
#(
  parameter int unsigned NI = N_IN,
  parameter int unsigned CW = CFG_W,
  localparam int unsigned LW = 1 << NI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NI-1:0]    trig_in_i,
  input  logic [NI*CW-1:0] delay_cfg_i,
  input  logic [NI*CW-1:0] stretch_cfg_i,
  input  logic [LW-1:0]    trig_word_i,
  output logic             trig_valid_o
);
  logic [NI-1:0] pulse_w;
  logic [NI-1:0] dly_w;
  logic [NI-1:0] cond_w;

  for (genvar i = 0; i < NI; i++) begin : g_ch
    trig_edge_det u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (trig_in_i[i]),
      .pulse_o (pulse_w[i])
    );
    trig_delay_line #(.CFG_W(CW)) u_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (pulse_w[i]),
      .dly_i   (delay_cfg_i[i*CW +: CW]),
      .pulse_o (dly_w[i])
    );
    trig_stretch #(.CFG_W(CW)) u_str (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (dly_w[i]),
      .str_i   (stretch_cfg_i[i*CW +: CW]),
      .level_o (cond_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_valid_o <= 1'b0;
    else         trig_valid_o <= trig_word_i[cond_w];
  end
endmodule

// File: rtl/trig_coinc_chk.sv
module trig_coinc_chk #(
  parameter int unsigned NI = 6,
  parameter int unsigned CW = 5,
  localparam int unsigned LW = 1 << NI
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NI-1:0]    trig_in_i,
  input logic [NI*CW-1:0] delay_cfg_i,
  input logic [LW-1:0]    trig_word_i,
  input logic             trig_valid_o,
  input logic [NI-1:0]    pulse_w,
  input logic [NI-1:0]    dly_w,
  input logic [NI-1:0]    cond_w
);
  for (genvar i = 0; i < NI; i++) begin : g_a
    // R1: a pulse needs the line sampled high then low
    p_fall_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_w[i] |-> (!$past(trig_in_i[i], 3) && $past(trig_in_i[i], 4)));

    // R2: edge pulse is one cycle wide
    p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_w[i] |=> !pulse_w[i]);

    // R3: zero delay passes the edge pulse straight through
    p_zero_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (delay_cfg_i[i*CW +: CW] == '0) |-> (dly_w[i] == pulse_w[i]));

    // R4: a delayed pulse always raises the conditioned level
    p_level_on_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dly_w[i] |-> cond_w[i]);
  end

  // R6: output follows the table bit picked one cycle earlier
  p_lut_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(trig_word_i) |=> (trig_valid_o == $past(trig_word_i[cond_w])));
endmodule

bind trig_coinc_top trig_coinc_chk #(.NI(NI), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_in_i    (trig_in_i),
  .delay_cfg_i  (delay_cfg_i),
  .trig_word_i  (trig_word_i),
  .trig_valid_o (trig_valid_o),
  .pulse_w      (pulse_w),
  .dly_w        (dly_w),
  .cond_w       (cond_w)
);

// File: tb/tb_trig_coinc_top.sv
module tb_trig_coinc_top;
  localparam int NI = 6;
  localparam int CW = 5;
  localparam int LW = 64;
  localparam time CLK_PERIOD = 6.25ns;
  localparam int WIN = 80;

  typedef struct packed {
    logic [NI-1:0] mask;
    logic [LW-1:0] word;
    logic [CW-1:0] dly;
    logic [CW-1:0] str;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'b000001, 64'h2,                  5'd0,  5'd0},
    '{6'b000010, 64'h4,                  5'd3,  5'd2},
    '{6'b100000, 64'h1 << 32,            5'd31, 5'd0},
    '{6'b000100, 64'h10,                 5'd0,  5'd31},
    '{6'b010001, 64'h1 << 17,            5'd1,  5'd4},
    '{6'b010001, 64'h2,                  5'd0,  5'd3},
    '{6'b001000, 64'h1 << 16,            5'd0,  5'd0},
    '{6'b111111, 64'h1 << 63,            5'd5,  5'd5},
    '{6'b000011, 64'hE,                  5'd2,  5'd1},
    '{6'b010000, 64'hFFFF_FFFF_FFFF_FFFE, 5'd7, 5'd7}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NI-1:0]    trig_in = '1;
  logic [NI*CW-1:0] dly_cfg = '0;
  logic [NI*CW-1:0] str_cfg = '0;
  logic [LW-1:0]    word = '0;
  logic             valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int dly_a [NI];
  int str_a [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_coinc_top dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .trig_in_i    (trig_in),
    .delay_cfg_i  (dly_cfg),
    .stretch_cfg_i(str_cfg),
    .trig_word_i  (word),
    .trig_valid_o (valid)
  );

  function automatic logic lvl(input int c, input int k, input logic [NI-1:0] m);
    return m[c] && (k >= 2 + dly_a[c]) && (k <= 2 + dly_a[c] + str_a[c]);
  endfunction

  function automatic logic exp_at(input int k, input logic [NI-1:0] m);
    logic [NI-1:0] idx = '0;
    for (int c = 0; c < NI; c++) idx[c] = lvl(c, k - 1, m);
    return word[idx];
  endfunction

  task automatic apply_cfg();
    for (int c = 0; c < NI; c++) begin
      dly_cfg[c*CW +: CW] = CW'(dly_a[c]);
      str_cfg[c*CW +: CW] = CW'(str_a[c]);
    end
  endtask

  // fall lines in mask, compare every cycle, then raise them and expect silence
  task automatic run_case(input logic [NI-1:0] m, input string tag);
    int bad = 0;
    logic got_bad = 1'b0, exp_bad = 1'b0;
    int bad_k = -1;
    for (int k = 0; k < WIN; k++) begin
      if (k == 0) trig_in = trig_in & ~m;
      @(posedge clk); @(negedge clk);
      if (valid !== exp_at(k, m)) begin
        if (bad == 0) begin bad_k = k; got_bad = valid; exp_bad = exp_at(k, m); end
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s: cycle %0d got %b exp %b", tag, bad_k, got_bad, exp_bad);
    end
    bad = 0;
    trig_in = '1;
    for (int k = 0; k < WIN; k++) begin
      @(posedge clk); @(negedge clk);
      if (valid !== 1'b0) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL R1 rising edge after %s: got 1 exp 0 in %0d cycles", tag, bad);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid !== 1'b0) begin n_bad++; $display("FAIL R8 in reset: got %b exp 0", valid); end
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    n_chk++;
    if (valid !== 1'b0) begin n_bad++; $display("FAIL R8 after reset: got %b exp 0", valid); end

    // R2 R3 R4 R6 R7 R9 table walk
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < NI; c++) begin
        dly_a[c] = int'(VECS[v].dly);
        str_a[c] = int'(VECS[v].str);
      end
      apply_cfg();
      word = VECS[v].word;
      repeat (2) @(negedge clk);
      run_case(VECS[v].mask, $sformatf("R2/R3/R4/R6 vector %0d", v));
    end

    // R7 double pulse: long IN_1, short delayed IN_5, table selects IN_1 alone
    // R9 distinct per-input settings
    for (int c = 0; c < NI; c++) begin dly_a[c] = 0; str_a[c] = 0; end
    dly_a[0] = 0;  str_a[0] = 10;
    dly_a[4] = 2;  str_a[4] = 2;
    apply_cfg();
    word = 64'h2;
    repeat (2) @(negedge clk);
    run_case(6'b010001, "R7 double pulse");

    // R9 unequal delays align a coincidence
    for (int c = 0; c < NI; c++) begin dly_a[c] = 0; str_a[c] = 0; end
    dly_a[1] = 9; dly_a[2] = 0; str_a[2] = 12; str_a[1] = 1;
    apply_cfg();
    word = 64'h1 << 6;
    repeat (2) @(negedge clk);
    run_case(6'b000110, "R9 per-input delay");

    // R5 retrigger during stretch: fall, rise, fall again 4 cycles later
    begin
      int bad = 0;
      for (int c = 0; c < NI; c++) begin dly_a[c] = 0; str_a[c] = 0; end
      str_a[0] = 10;
      apply_cfg();
      word = 64'h2;
      repeat (2) @(negedge clk);
      for (int k = 0; k < WIN; k++) begin
        if (k == 0) trig_in[0] = 1'b0;
        if (k == 2) trig_in[0] = 1'b1;
        if (k == 4) trig_in[0] = 1'b0;
        @(posedge clk); @(negedge clk);
        if (valid !== ((k >= 3) && (k <= 17))) begin
          bad++;
          $display("FAIL R5 retrigger cycle %0d: got %b exp %b", k, valid, (k >= 3) && (k <= 17));
        end
      end
      n_chk++;
      if (bad != 0) n_bad++;
      trig_in = '1;
      repeat (WIN) @(negedge clk);
    end

    // R8 reset mid-window clears output
    str_a[0] = 31;
    apply_cfg();
    trig_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    n_chk++;
    if (valid !== 1'b0) begin n_bad++; $display("FAIL R8 async reset: got %b exp 0", valid); end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    n_chk++;
    if (valid !== 1'b0) begin n_bad++; $display("FAIL R8 no pulse when low at release: got %b exp 0", valid); end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule